// File: doc/BRIEF.md
# Converter Conversion Sequencer

This block is the digital controller of an 8-bit sampling converter. The converter runs on its own clock. A write strobe on the bus side asks for a conversion. The request crosses into the converter clock domain, and the sequencer then holds the converter busy for a fixed number of converter clocks. At the last of those clocks it registers the sample word and sends it back to the bus domain. There, the word lands in a result register and raises a completion flag.

The sample arrives already digitized, as a code plus two range flags. One flag marks an input above the upper reference and the other an input below the lower reference. Codes between the references pass through unchanged, so the transfer is a straight line. Out-of-range inputs pin the result to the nearest end of the code range.

A write that arrives while a conversion is running cancels that conversion and starts the full count again. The cancelled conversion never updates the result.

Top module: `adc_seq_top`

## Requirements
- R1: A pulse on `ctrl_wr` flips a bus-side request toggle. The toggle passes through a `SYNC_STAGES`-deep synchronizer, and the converter starts on the first converter edge that sees the synchronized level change.
- R2: A conversion lasts `CONV_CYCLES` (16) converter clocks. The result word is registered on the 16th converter edge after the start edge.
- R3: With the default parameters, a 40 ns converter clock and a 10 ns bus clock, `complete` first reads 1 between 75 and 78 bus edges after the edge that sampled `ctrl_wr`. It is never 1 earlier than that.
- R4: When `sample_over_hi` is 1, the result is 0xFF. When only `sample_under_lo` is 1, the result is 0x00. When both are 1, the over-range flag wins.
- R5: When neither range flag is set, the result equals `sample_code`, and this includes the end codes 0x00 and 0xFF.
- R6: `complete` drops on the edge after a `result_rd` or a `ctrl_wr`. A completion arriving on the same edge as `result_rd` leaves `complete` at 1. A completion arriving on the same edge as `ctrl_wr` is discarded.
- R7: `result` keeps its previous value until the bus side accepts a new completion. It changes only on an edge that also sets `complete`.
- R8: A `ctrl_wr` during a running conversion cancels it. The cancelled conversion never reaches `result`, and the next completion follows the R3 window measured from the last write.
- R9: After reset, `result` is 0x00 and `complete` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| conv_clk | input | 1 | Converter clock |
| conv_rst | input | 1 | Synchronous active-high reset, converter domain |
| ctrl_wr | input | 1 | One-cycle control write strobe; requests a conversion |
| result_rd | input | 1 | One-cycle result read strobe; clears the flag |
| sample_code | input | 8 | Digitized input code, held stable by the front end |
| sample_over_hi | input | 1 | Input lies above the upper reference |
| sample_under_lo | input | 1 | Input lies below the lower reference |
| result | output | 8 | Last accepted conversion result |
| complete | output | 1 | Conversion-complete flag |

## Verification
Two events can land on the same bus edge: the arrival of a finished conversion and a read strobe that would clear the flag. The bench provokes this by holding `result_rd` high for the whole conversion. The arrival therefore coincides with a read whatever the clock phase. The reference model requires `complete` to be 1 on that edge, inside the latency window, and 0 on the next. The cancel-and-restart case also matters: a second write lands mid-conversion, and the model demands that `result` stay unchanged until the full window after that second write.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int CODE_W = 8;

    typedef logic [CODE_W-1:0] code_t;

    // Digitized sample as delivered by the front end
    typedef struct packed {
        code_t code;
        logic  over_hi;
        logic  under_lo;
    } sample_t;

    // Word handed from the converter domain back to the bus domain
    typedef struct packed {
        code_t value;
        logic  tag;
    } done_word_t;

    // Over-range wins, then under-range, else the code passes straight through
    function automatic code_t clamp_code(sample_t s);
        if (s.over_hi)
            return '1;
        if (s.under_lo)
            return '0;
        return s.code;
    endfunction

endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_req_xfer.sv
module adc_req_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic wr,
    output logic req_level,
    input  logic conv_clk,
    input  logic conv_rst,
    output logic start,
    output logic start_tag
);
    logic req_tgl;
    logic req_sync;
    logic req_seen;

    // Bus side: every write flips the toggle
    always_ff @(posedge bus_clk) begin
        if (bus_rst)  req_tgl <= 1'b0;
        else if (wr)  req_tgl <= ~req_tgl;
    end
    assign req_level = req_tgl;

    adc_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (conv_clk),
        .rst (conv_rst),
        .d   (req_tgl),
        .q   (req_sync)
    );

    always_ff @(posedge conv_clk) begin
        if (conv_rst) req_seen <= 1'b0;
        else          req_seen <= req_sync;
    end

    assign start     = req_sync ^ req_seen;
    assign start_tag = req_sync;

    // R1: a start pulse is one converter cycle wide
    assert_start_single_R1: assert property (@(posedge conv_clk) disable iff (conv_rst)
        start |=> !start);
endmodule

// File: rtl/adc_conv_core.sv
module adc_conv_core
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 16
) (
    input  logic       conv_clk,
    input  logic       conv_rst,
    input  logic       start,
    input  logic       start_tag,
    input  sample_t    sample,
    output logic       done_tgl,
    output done_word_t done_word
);
    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             run_tag;

    always_ff @(posedge conv_clk) begin
        if (conv_rst) begin
            busy      <= 1'b0;
            cnt       <= '0;
            run_tag   <= 1'b0;
            done_tgl  <= 1'b0;
            done_word <= '0;
        end else if (start) begin
            // A new request restarts the count, cancelling any run in flight
            busy    <= 1'b1;
            cnt     <= '0;
            run_tag <= start_tag;
        end else if (busy) begin
            if (cnt == LAST) begin
                busy            <= 1'b0;
                done_word.value <= clamp_code(sample);
                done_word.tag   <= run_tag;
                done_tgl        <= ~done_tgl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R1: a start always leaves the core busy at the first count
    assert_start_loads_R1: assert property (@(posedge conv_clk) disable iff (conv_rst)
        start |=> (busy && cnt == '0));

    // R2: a completion only follows a busy cycle at the final count
    assert_done_after_count_R2: assert property (@(posedge conv_clk) disable iff (conv_rst)
        (done_tgl != $past(done_tgl)) |-> ($past(busy) && $past(cnt) == LAST && !$past(start)));

    // R4: an over-range sample yields full scale
    assert_over_full_R4: assert property (@(posedge conv_clk) disable iff (conv_rst)
        ((done_tgl != $past(done_tgl)) && $past(sample.over_hi)) |-> (done_word.value == '1));

    // R4: an under-range sample without over-range yields zero
    assert_under_zero_R4: assert property (@(posedge conv_clk) disable iff (conv_rst)
        ((done_tgl != $past(done_tgl)) && $past(sample.under_lo) && !$past(sample.over_hi))
        |-> (done_word.value == '0));
endmodule

// File: rtl/adc_done_xfer.sv
module adc_done_xfer
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       bus_clk,
    input  logic       bus_rst,
    input  logic       done_tgl,
    input  done_word_t done_word,
    input  logic       req_level,
    input  logic       ctrl_wr,
    input  logic       result_rd,
    output code_t      result,
    output logic       complete
);
    logic done_sync;
    logic done_seen;
    logic arrive;
    logic accept;

    adc_bit_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (done_tgl),
        .q   (done_sync)
    );

    always_ff @(posedge bus_clk) begin
        if (bus_rst) done_seen <= 1'b0;
        else         done_seen <= done_sync;
    end

    // The word is stable for a whole conversion once the toggle has moved.
    // A tag that no longer matches the request toggle marks a cancelled run.
    assign arrive = done_sync ^ done_seen;
    assign accept = arrive && (done_word.tag == req_level) && !ctrl_wr;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            complete <= 1'b0;
            result   <= '0;
        end else begin
            if (accept) begin
                complete <= 1'b1;
                result   <= done_word.value;
            end else if (ctrl_wr || result_rd) begin
                complete <= 1'b0;
            end
        end
    end

    // R6: a control write always leaves the flag low on the next edge
    assert_wr_clears_R6: assert property (@(posedge bus_clk) disable iff (bus_rst)
        ctrl_wr |=> !complete);

    // R7: the result only moves on an edge that raises the flag
    assert_result_hold_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (result != $past(result)) |-> complete);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int CONV_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst,
    input  logic        conv_clk,
    input  logic        conv_rst,
    input  logic        ctrl_wr,
    input  logic        result_rd,
    input  logic [7:0]  sample_code,
    input  logic        sample_over_hi,
    input  logic        sample_under_lo,
    output logic [7:0]  result,
    output logic        complete
);
    logic       req_level;
    logic       start;
    logic       start_tag;
    logic       done_tgl;
    done_word_t done_word;
    sample_t    sample;

    assign sample.code     = sample_code;
    assign sample.over_hi  = sample_over_hi;
    assign sample.under_lo = sample_under_lo;

    adc_req_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .wr        (ctrl_wr),
        .req_level (req_level),
        .conv_clk  (conv_clk),
        .conv_rst  (conv_rst),
        .start     (start),
        .start_tag (start_tag)
    );

    adc_conv_core #(.CONV_CYCLES(CONV_CYCLES)) u_core (
        .conv_clk  (conv_clk),
        .conv_rst  (conv_rst),
        .start     (start),
        .start_tag (start_tag),
        .sample    (sample),
        .done_tgl  (done_tgl),
        .done_word (done_word)
    );

    adc_done_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_done (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .done_tgl  (done_tgl),
        .done_word (done_word),
        .req_level (req_level),
        .ctrl_wr   (ctrl_wr),
        .result_rd (result_rd),
        .result    (result),
        .complete  (complete)
    );

    // R9: out of reset the flag is low
    assert_reset_flag_R9: assert property (@(posedge bus_clk)
        $past(bus_rst) |-> !complete);
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
    localparam int LAT_MIN = 75;
    localparam int LAT_MAX = 78;

    logic       bus_clk;
    logic       bus_rst;
    logic       conv_clk;
    logic       conv_rst;
    logic       ctrl_wr;
    logic       result_rd;
    logic [7:0] sample_code;
    logic       sample_over_hi;
    logic       sample_under_lo;
    logic [7:0] result;
    logic       complete;

    int tests  = 0;
    int fails  = 0;
    bit ended  = 0;

    // Reference model state
    bit       pending  = 0;
    int       cyc      = 0;
    bit       exp_flag = 0;
    bit [7:0] exp_res  = 8'h00;
    bit [7:0] exp_code = 8'h00;

    adc_seq_top u_dut (
        .bus_clk         (bus_clk),
        .bus_rst         (bus_rst),
        .conv_clk        (conv_clk),
        .conv_rst        (conv_rst),
        .ctrl_wr         (ctrl_wr),
        .result_rd       (result_rd),
        .sample_code     (sample_code),
        .sample_over_hi  (sample_over_hi),
        .sample_under_lo (sample_under_lo),
        .result          (result),
        .complete        (complete)
    );

    initial begin
        bus_clk = 1'b0;
        forever #5 bus_clk = ~bus_clk;
    end

    initial begin
        conv_clk = 1'b0;
        #17;
        forever begin
            conv_clk = 1'b1;
            #20;
            conv_clk = 1'b0;
            #20;
        end
    end

    function automatic bit [7:0] model_code(bit [7:0] c, bit hi, bit lo);
        if (hi) return 8'hFF;
        if (lo) return 8'h00;
        return c;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Cycle-by-cycle reference model, checked 3 ns after each bus edge
    always @(posedge bus_clk) begin
        bit       wr_seen;
        bit       rd_seen;
        bit [7:0] code_seen;
        wr_seen   = ctrl_wr;
        rd_seen   = result_rd;
        code_seen = model_code(sample_code, sample_over_hi, sample_under_lo);
        #3;
        if (bus_rst) begin
            pending  = 0;
            exp_flag = 0;
            exp_res  = 8'h00;
        end else if (wr_seen) begin
            // R8: a write restarts the window; R6: the flag drops
            pending  = 1;
            cyc      = 0;
            exp_flag = 0;
            exp_code = code_seen;
            chk(complete == 1'b0, "R6 write clears flag", complete, 0);
            chk(result == exp_res, "R7 result held on write", result, exp_res);
        end else if (pending) begin
            cyc++;
            if (complete) begin
                chk(cyc >= LAT_MIN && cyc <= LAT_MAX, "R1 R2 R3 latency", cyc, LAT_MIN);
                chk(result == exp_code, "R4 R5 result value", result, exp_code);
                exp_res  = exp_code;
                exp_flag = 1;
                pending  = 0;
            end else begin
                chk(result == exp_res, "R7 result held while busy", result, exp_res);
                if (cyc > LAT_MAX) begin
                    chk(1'b0, "R3 completion missing", cyc, LAT_MAX);
                    pending = 0;
                end
            end
        end else begin
            if (rd_seen) exp_flag = 0;
            chk(complete == exp_flag, "R6 flag state", complete, exp_flag);
            chk(result == exp_res, "R7 result stable when idle", result, exp_res);
        end
    end

    task automatic pulse_wr();
        @(negedge bus_clk) ctrl_wr = 1'b1;
        @(negedge bus_clk) ctrl_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge bus_clk) result_rd = 1'b1;
        @(negedge bus_clk) result_rd = 1'b0;
    endtask

    task automatic set_sample(bit [7:0] c, bit hi, bit lo);
        @(negedge bus_clk);
        sample_code     = c;
        sample_over_hi  = hi;
        sample_under_lo = lo;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge bus_clk);
    endtask

    task automatic convert(bit [7:0] c, bit hi, bit lo, string req);
        set_sample(c, hi, lo);
        pulse_wr();
        idle(LAT_MAX + 4);
        chk(complete == 1'b1, {req, " flag after conversion"}, complete, 1);
        chk(result == model_code(c, hi, lo), {req, " converted code"}, result,
            model_code(c, hi, lo));
        pulse_rd();
        idle(2);
        chk(complete == 1'b0, "R6 read clears flag", complete, 0);
    endtask

    initial begin
        ctrl_wr         = 1'b0;
        result_rd       = 1'b0;
        sample_code     = 8'h00;
        sample_over_hi  = 1'b0;
        sample_under_lo = 1'b0;
        bus_rst         = 1'b1;
        conv_rst        = 1'b1;
        idle(12);
        bus_rst  = 1'b0;
        conv_rst = 1'b0;
        idle(2);
        chk(result == 8'h00, "R9 reset result", result, 0);
        chk(complete == 1'b0, "R9 reset flag", complete, 0);

        // R5: in-range codes pass through, including both ends
        convert(8'h5A, 1'b0, 1'b0, "R5");
        convert(8'h00, 1'b0, 1'b0, "R5");
        convert(8'hFF, 1'b0, 1'b0, "R5");
        // R4: saturation and priority of over-range
        convert(8'h10, 1'b1, 1'b0, "R4");
        convert(8'h80, 1'b0, 1'b1, "R4");
        convert(8'h33, 1'b1, 1'b1, "R4");

        // R8: cancel mid-conversion, then restart with a new code
        set_sample(8'h11, 1'b0, 1'b0);
        pulse_wr();
        idle(40);
        chk(complete == 1'b0, "R8 no flag mid-conversion", complete, 0);
        set_sample(8'h22, 1'b0, 1'b0);
        pulse_wr();
        idle(LAT_MAX + 20);
        chk(result == 8'h22, "R8 restarted result", result, 8'h22);
        chk(complete == 1'b1, "R8 restarted flag", complete, 1);

        // R6: a write clears a set flag
        set_sample(8'h66, 1'b0, 1'b0);
        pulse_wr();
        chk(complete == 1'b0, "R6 write clears set flag", complete, 0);
        idle(LAT_MAX + 4);
        chk(result == 8'h66, "R7 result after write", result, 8'h66);

        // R6: completion coincides with a held read; set must win for one cycle
        set_sample(8'h44, 1'b0, 1'b0);
        @(negedge bus_clk);
        ctrl_wr   = 1'b1;
        result_rd = 1'b1;
        @(negedge bus_clk);
        ctrl_wr   = 1'b0;
        idle(LAT_MAX + 4);
        result_rd = 1'b0;
        idle(2);
        chk(complete == 1'b0, "R6 flag cleared by held read", complete, 0);
        chk(result == 8'h44, "R6 result under held read", result, 8'h44);

        idle(5);
        finish_run();
    end

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end
endmodule